// File: doc/BRIEF.md
# Cyclic-code syndrome and position-class classifier

This block is the front end of a double-error-correcting decoder for a 15-bit cyclic code that carries 7 data bits and 8 check bits. It takes one received word and computes two 4-bit syndromes. The first is the remainder of the word polynomial modulo x^4 + x + 1. The second is the remainder modulo x^4 + x^3 + x^2 + x + 1. The block is purely combinational, so all outputs follow the input word in the same cycle.

The second modulus divides x^5 + 1, so the second syndrome only depends on which residue classes modulo 5 of the bit positions hold an odd number of errors. There are five such classes. An error in class k (k from 0 to 3) sets only syndrome bit k. An error in class 4 sets all four bits.

From the second syndrome the block derives a 5-bit class vector. It does this without counting ones. A small at-least-three-ones detector marks class 4, and the same detector conditionally inverts the syndrome to give the flags for classes 0 to 3. A later error-location stage uses this vector together with the first syndrome.

Top module: `bch_col_classifier`

## Requirements
- R1: `syn_a_o` equals the remainder of the word polynomial (bit i of `word_i` is the coefficient of x^i) modulo x^4 + x + 1. Bit 0 of the syndrome is the constant coefficient.
- R2: `syn_b_o` equals the remainder of the word polynomial modulo x^4 + x^3 + x^2 + x + 1. Bit 0 is the constant coefficient.
- R3: For any codeword, meaning any multiple of x^8 + x^7 + x^6 + x^4 + 1, both syndromes are zero, `class_o` is 00000 and `heavy_o` is 0.
- R4: A single flipped bit at position p with p mod 5 = k < 4 gives `syn_b_o` with only bit k set. It also gives `class_o` with only bit k set and `heavy_o` = 0.
- R5: A single flipped bit at position p with p mod 5 = 4 gives `syn_b_o` = 1111, `heavy_o` = 1 and `class_o` = 10000 (bit 4 only).
- R6: `heavy_o` is 1 exactly when `syn_b_o` has three or more bits set.
- R7: `class_o[4]` equals `heavy_o`. `class_o[3:0]` equals `syn_b_o` when `heavy_o` is 0, and equals the inverse of `syn_b_o` when `heavy_o` is 1.
- R8: Two flipped bits in the same residue class cancel. `syn_b_o` is 0000 and `class_o` is 00000, while `syn_a_o` is nonzero.
- R9: Two flipped bits in different residue classes give a `class_o` with exactly those two class bits set. This includes the case where one of the two classes is class 4.
- R10: The outputs depend only on the present `word_i`. There is no storage and no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | 15 | Received word; bit i is the coefficient of x^i |
| syn_a_o | output | 4 | Remainder modulo x^4 + x + 1 |
| syn_b_o | output | 4 | Remainder modulo x^4 + x^3 + x^2 + x + 1 |
| class_o | output | 5 | One flag per residue class modulo 5 that holds an odd number of errors |
| heavy_o | output | 1 | Second syndrome has three or more ones; also the class-4 flag |

## Verification
The hardest case to reach is a class-4 error paired with an error in another class. Here the second syndrome has three ones, and the class flags are correct only because of the conditional inversion. The mirror case is two errors in one class, where the second syndrome must vanish while the first does not.

The stimulus reaches both cases by running every pattern of weight 0, 1 and 2 over several random codewords. A reference long division and a class-parity count give the expected values. A short table of hand-picked patterns pins these cases down explicitly.

// File: rtl/bch_cls_pkg.sv
package bch_cls_pkg;

    localparam int WORD_W  = 15;
    localparam int SYN_W   = 4;
    localparam int CLASS_W = SYN_W + 1;

    // Moduli as full polynomials (bit SYN_W is the leading term)
    localparam logic [16:0] POLY_A = 17'h00013;  // x^4 + x + 1
    localparam logic [16:0] POLY_B = 17'h0001F;  // x^4 + x^3 + x^2 + x + 1

    // x^i reduced modulo poly of degree m; result in low m bits
    function automatic logic [15:0] xpow_mod(int i, int m, logic [16:0] poly);
        logic [16:0] r;
        r = 17'd1;
        for (int k = 0; k < i; k++) begin
            r = r << 1;
            if (r[m]) r = r ^ poly;
        end
        return r[15:0];
    endfunction

endpackage

// File: rtl/bch_syn_unit.sv
module bch_syn_unit
    import bch_cls_pkg::*;
#(
    parameter int          N    = 15,
    parameter int          M    = 4,
    parameter logic [16:0] POLY = 17'h00013
) (
    input  logic [N-1:0] word_i,
    output logic [M-1:0] syn_o
);

    logic [M-1:0] term [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_term
            localparam logic [15:0] PW   = xpow_mod(i, M, POLY);
            localparam logic [M-1:0] PWM = PW[M-1:0];
            assign term[i] = word_i[i] ? PWM : '0;
        end
    endgenerate

    always_comb begin
        syn_o = '0;
        for (int i = 0; i < N; i++) begin
            syn_o = syn_o ^ term[i];
        end
    end

endmodule

// File: rtl/bch_class_det.sv
module bch_class_det
    import bch_cls_pkg::*;
(
    input  logic [SYN_W-1:0]   syn_b_i,
    output logic [CLASS_W-1:0] class_o,
    output logic               heavy_o
);

    logic a, b, c, d;

    assign {d, c, b, a} = syn_b_i;

    // at least three of four ones: four 3-input ANDs, OR-reduced
    assign heavy_o = (a & b & c) | (a & b & d) | (a & c & d) | (b & c & d);

    generate
        for (genvar k = 0; k < SYN_W; k++) begin : g_flag
            assign class_o[k] = syn_b_i[k] ^ heavy_o;
        end
    endgenerate

    assign class_o[SYN_W] = heavy_o;

endmodule

// File: rtl/bch_col_classifier.sv
module bch_col_classifier
    import bch_cls_pkg::*;
(
    input  logic [14:0] word_i,
    output logic [3:0]  syn_a_o,
    output logic [3:0]  syn_b_o,
    output logic [4:0]  class_o,
    output logic        heavy_o
);

    bch_syn_unit #(.N(WORD_W), .M(SYN_W), .POLY(POLY_A)) u_syn_a (
        .word_i (word_i),
        .syn_o  (syn_a_o)
    );

    bch_syn_unit #(.N(WORD_W), .M(SYN_W), .POLY(POLY_B)) u_syn_b (
        .word_i (word_i),
        .syn_o  (syn_b_o)
    );

    bch_class_det u_cls (
        .syn_b_i (syn_b_o),
        .class_o (class_o),
        .heavy_o (heavy_o)
    );

endmodule

// File: rtl/bch_cls_chk.sv
module bch_cls_chk (
    input logic [3:0] syn_a_o,
    input logic [3:0] syn_b_o,
    input logic [4:0] class_o,
    input logic       heavy_o
);

    always_comb begin
        // R6
        heavy_thr_chk: assert (heavy_o == ($countones(syn_b_o) >= 3));
        // R3
        clean_word_chk: assert (!(syn_a_o == 4'd0 && syn_b_o == 4'd0) || (class_o == 5'd0 && !heavy_o));
        // R4
        single_low_chk: assert (!$onehot(syn_b_o) || (class_o == {1'b0, syn_b_o}));
        // R5
        single_top_chk: assert (syn_b_o != 4'hF || class_o == 5'b10000);
        // R8
        cancel_chk: assert (syn_b_o != 4'd0 || class_o == 5'd0);
        // R9
        pair_count_chk: assert ($countones(class_o) <= 2);
    end

endmodule

bind bch_col_classifier bch_cls_chk u_chk (
    .syn_a_o (syn_a_o),
    .syn_b_o (syn_b_o),
    .class_o (class_o),
    .heavy_o (heavy_o)
);

// File: tb/bch_col_classifier_test.sv
module bch_col_classifier_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] word;
    logic [3:0]  syn_a, syn_b;
    logic [4:0]  cls;
    logic        heavy;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    bch_col_classifier uut (
        .word_i  (word),
        .syn_a_o (syn_a),
        .syn_b_o (syn_b),
        .class_o (cls),
        .heavy_o (heavy)
    );

    // error pattern, expected class vector
    localparam int NV = 10;
    localparam logic [19:0] VEC [NV] = '{
        {15'h0001, 5'b00001},
        {15'h0010, 5'b10000},
        {15'h0200, 5'b10000},
        {15'h0014, 5'b10100},
        {15'h0021, 5'b00000},
        {15'h4008, 5'b11000},
        {15'h0006, 5'b00110},
        {15'h4001, 5'b10001},
        {15'h1080, 5'b00000},
        {15'h0401, 5'b00000}
    };

    function automatic logic [3:0] ref_rem(logic [14:0] w, logic [4:0] g);
        logic [14:0] r;
        r = w;
        for (int i = 14; i >= 4; i--) begin
            if (r[i]) r = r ^ (15'(g) << (i - 4));
        end
        return r[3:0];
    endfunction

    function automatic logic [14:0] encode(logic [6:0] m);
        logic [14:0] cw;
        cw = '0;
        for (int i = 0; i < 7; i++) begin
            if (m[i]) cw = cw ^ (15'h01D1 << i);
        end
        return cw;
    endfunction

    function automatic logic [4:0] class_par(logic [14:0] e);
        logic [4:0] c;
        c = '0;
        for (int i = 0; i < 15; i++) begin
            if (e[i]) c[i % 5] = ~c[i % 5];
        end
        return c;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h word=%h", req, act, exp, word);
        end
    endtask

    task automatic apply(logic [14:0] w);
        @(negedge clk);
        word = w;
        #1;
    endtask

    // full comparison of one codeword plus error pattern
    task automatic run_one(logic [14:0] cw, logic [14:0] e, int wt);
        logic [3:0] ea, eb;
        logic [4:0] ec;
        apply(cw ^ e);
        ea = ref_rem(cw ^ e, 5'b10011);
        eb = ref_rem(cw ^ e, 5'b11111);
        ec = class_par(e);
        check("R1", 32'(syn_a), 32'(ea));
        check("R2", 32'(syn_b), 32'(eb));
        check("R6", 32'(heavy), 32'($countones(eb) >= 3));
        if (wt == 0) check("R3", 32'({syn_a, syn_b, cls}), 32'd0);
        else if (wt == 1 && ec[4]) check("R5", 32'({cls, syn_b}), 32'({5'b10000, 4'hF}));
        else if (wt == 1) check("R4", 32'(cls), 32'(ec));
        else if (ec == 5'd0) check("R8", 32'({cls, syn_b, (syn_a != 4'd0)}), 32'd1);
        else check("R9", 32'(cls), 32'(ec));
    endtask

    initial begin
        logic [14:0] cw;
        word = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        // reset-time state: zero word
        check("R3", 32'({syn_a, syn_b, cls, heavy}), 32'd0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][19:5]);
            check("R9", 32'(cls), 32'(VEC[v][4:0]));
            check("R7", 32'(cls), 32'({heavy, syn_b ^ {4{heavy}}}));
        end

        // exhaustive weight 0..2 over several codewords
        for (int c = 0; c < 6; c++) begin
            cw = (c == 0) ? 15'd0 : (c == 1) ? encode(7'h7F) : encode(7'($urandom));
            run_one(cw, 15'd0, 0);
            for (int i = 0; i < 15; i++) begin
                run_one(cw, 15'd1 << i, 1);
                for (int j = i + 1; j < 15; j++) begin
                    run_one(cw, (15'd1 << i) | (15'd1 << j), 2);
                end
            end
        end

        // R10: same word twice, unchanged outputs, no lag after change
        apply(15'h0010);
        check("R10", 32'({syn_b, cls}), 32'({4'hF, 5'b10000}));
        @(posedge clk);
        #1;
        check("R10", 32'({syn_b, cls}), 32'({4'hF, 5'b10000}));
        apply(15'h0002);
        check("R10", 32'({syn_b, cls}), 32'({4'b0010, 5'b00010}));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule